// File: doc/BRIEF.md
# Static Memory Read Timing Sequencer

This block runs read cycles on an external asynchronous static memory that is split into four banks. Each bank has its own chip-select line. The address bus, the shared output-enable line and the 16-bit data bus are common to all banks. A register port holds a separate timing set for each bank. Each set has six cycle counts, a data width of one or two bytes and a page-mode flag. The host raises a request that names a bank and an address. The block then walks through the phases in this order: address setup, chip-select setup, access, optional page beats, chip-select hold and address hold. For every data beat the host receives a one-cycle valid pulse together with the read word.

With page mode off, each access returns one beat. With page mode on, output-enable and chip-select stay low for four beats in a row. Each beat after the first uses the shorter page-beat time, and the two address bits just above the byte-lane bits count 0, 1, 2, 3. A bank set to one byte wide returns the low data byte with zeros above it. A new request is taken only after the address-hold phase has ended and the block has spent one cycle idle.

Top module: `smc_read_seq`

## Requirements
- R1: After reset every chip-select and output-enable line is high (inactive), address-valid and read-valid are low, and req_ready is high.
- R2: After a request is accepted, address-valid is high for exactly Tacs cycles before a chip-select falls. The line that falls is mem_cs_n bit number req_bank, and no other bit falls.
- R3: Chip-select is low with output-enable high for exactly Tcos cycles before output-enable falls. Output-enable is never low while all chip-selects are high.
- R4: With page mode off, output-enable stays low for Tacc+1 cycles. rd_valid pulses once, in the cycle after the last output-enable-low cycle, and carries the data bus value sampled on that last cycle.
- R5: After output-enable rises, chip-select stays low for exactly Tcoh cycles.
- R6: After chip-select rises, address-valid stays high for exactly Tcah cycles. req_ready is low from acceptance until address-valid has fallen.
- R7: With page mode on, output-enable stays low without a gap for Tacc+1+3*max(Tacp,1) cycles and four rd_valid pulses occur. Address bits [L+1:L] take the values 0,1,2,3 for the four beats, where L is 0 for a one-byte bank and 1 for a two-byte bank.
- R8: A one-byte bank returns rd_data = {8'h00, data[7:0]}. A two-byte bank returns all 16 bits.
- R9: A bank that has never been written uses all timings 0, one-byte width and page mode off. Its access has a single output-enable-low cycle and no setup or hold cycles.
- R10: A configuration write changes only the bank it names (cfg_bank). The other banks keep their timings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for one bank's timing set |
| cfg_bank | input | 2 | Bank whose timing set is written |
| cfg_acs | input | 4 | Address setup cycles before chip-select |
| cfg_cos | input | 4 | Chip-select setup cycles before output-enable |
| cfg_acc | input | 5 | Access phase length minus one |
| cfg_coh | input | 4 | Chip-select hold cycles after output-enable |
| cfg_cah | input | 4 | Address hold cycles after chip-select |
| cfg_acp | input | 4 | Page beat cycles (0 treated as 1) |
| cfg_wide | input | 1 | 1 = two-byte bank, 0 = one-byte bank |
| cfg_page | input | 1 | 1 = four-beat page access |
| req_valid | input | 1 | Read request, held until accepted |
| req_bank | input | 2 | Bank of the request |
| req_addr | input | 24 | Address of the request |
| req_ready | output | 1 | High when a request can be accepted |
| rd_valid | output | 1 | One-cycle pulse per data beat |
| rd_data | output | 16 | Read word for the beat |
| mem_addr | output | 24 | Memory address bus |
| mem_addr_vld | output | 1 | Address bus driven by an access |
| mem_cs_n | output | 4 | Active-low chip-select, one per bank |
| mem_oe_n | output | 1 | Active-low output-enable |
| mem_data | input | 16 | Memory data bus |

## Verification
The bench measures phase lengths at the ports and compares them with the programmed values. The timing sets it uses are all zeros, mixed small values, the maximum of every field, and page mode with both a zero and a nonzero beat time. Together these separate skipped phases, off-by-one counters and page beats that are clamped or not. The memory model returns data derived from the address, so every word also confirms which address was on the bus for its beat and which byte lane was chosen. Rewriting one bank and then reading another shows that the timing sets are kept per bank. Back-to-back requests show that acceptance waits for the hold phase to end.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int TW     = 4;   // width of the 0..15 timing fields
  localparam int TACC_W = 5;   // width of the access field
  localparam int CNT_W  = TACC_W;

  typedef struct packed {
    logic              page;
    logic              wide;
    logic [TW-1:0]     acp;
    logic [TW-1:0]     cah;
    logic [TW-1:0]     coh;
    logic [TW-1:0]     cos;
    logic [TW-1:0]     acs;
    logic [TACC_W-1:0] acc;
  } bank_cfg_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ACS, PH_COS, PH_ACC, PH_PAGE, PH_COH, PH_CAH
  } phase_t;

  typedef struct packed {
    phase_t           ph;
    logic [CNT_W-1:0] cnt;
  } step_t;

  // Enter phase ph, skipping forward over phases whose length is zero.
  function automatic step_t enter(phase_t ph, bank_cfg_t c);
    step_t s;
    s.ph  = PH_IDLE;
    s.cnt = '0;
    if (ph == PH_ACS && c.acs != '0) begin
      s.ph = PH_ACS; s.cnt = CNT_W'(c.acs) - CNT_W'(1);
    end else if ((ph inside {PH_ACS, PH_COS}) && c.cos != '0) begin
      s.ph = PH_COS; s.cnt = CNT_W'(c.cos) - CNT_W'(1);
    end else if (ph inside {PH_ACS, PH_COS, PH_ACC}) begin
      s.ph = PH_ACC; s.cnt = c.acc;
    end else if (ph == PH_COH && c.coh != '0) begin
      s.ph = PH_COH; s.cnt = CNT_W'(c.coh) - CNT_W'(1);
    end else if ((ph inside {PH_COH, PH_CAH}) && c.cah != '0) begin
      s.ph = PH_CAH; s.cnt = CNT_W'(c.cah) - CNT_W'(1);
    end
    return s;
  endfunction
endpackage

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs
  import smc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  bank_cfg_t         wr_cfg,
  input  logic [BANK_W-1:0] rd_bank,
  output bank_cfg_t         rd_cfg
);
  bank_cfg_t regs [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)                                     regs[b] <= '0;
      else if (wr_en && wr_bank == BANK_W'(b))     regs[b] <= wr_cfg;
    end
  end

  assign rd_cfg = regs[rd_bank];
endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int PAGE_BEATS = 4,     // power of two
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int BEAT_W    = $clog2(PAGE_BEATS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [ADDR_W-1:0]    req_addr,
  input  bank_cfg_t            cfg_in,
  output logic                 req_ready,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_addr_vld,
  output logic [NUM_BANKS-1:0] mem_cs_n,
  output logic                 mem_oe_n,
  input  logic [DATA_W-1:0]    mem_data
);
  localparam int HALF_W = DATA_W / 2;

  phase_t             phase, nxt_phase;
  logic [CNT_W-1:0]   cnt, nxt_cnt;
  logic [BEAT_W-1:0]  beat, nxt_beat;
  bank_cfg_t          cur, nxt_cfg;
  logic [BANK_W-1:0]  bank_q, nxt_bank;
  logic [ADDR_W-1:0]  base_q, nxt_base;
  logic               accept, sample, last;
  logic [CNT_W-1:0]   beat_len;
  logic [NUM_BANKS-1:0] sel;
  step_t              s;

  function automatic logic [ADDR_W-1:0] beat_addr(
      logic [ADDR_W-1:0] a, logic [BEAT_W-1:0] k, bank_cfg_t c);
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] val;
    mask = ADDR_W'(PAGE_BEATS - 1) << c.wide;
    val  = ADDR_W'(k) << c.wide;
    return c.page ? ((a & ~mask) | val) : a;
  endfunction

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && (phase == PH_IDLE);
  assign last      = (cnt == '0);
  assign sample    = last && (phase inside {PH_ACC, PH_PAGE});
  assign beat_len  = (cur.acp == '0) ? '0 : CNT_W'(cur.acp) - CNT_W'(1);
  assign nxt_cfg   = accept ? cfg_in   : cur;
  assign nxt_bank  = accept ? req_bank : bank_q;
  assign nxt_base  = accept ? req_addr : base_q;

  always_comb begin
    nxt_phase = phase;
    nxt_cnt   = cnt - CNT_W'(1);
    nxt_beat  = beat;
    s         = '0;
    unique case (phase)
      PH_IDLE: begin
        nxt_cnt = cnt;
        if (accept) begin
          s = enter(PH_ACS, cfg_in);
          nxt_phase = s.ph; nxt_cnt = s.cnt; nxt_beat = '0;
        end
      end
      PH_ACS: if (last) begin
        s = enter(PH_COS, cur); nxt_phase = s.ph; nxt_cnt = s.cnt;
      end
      PH_COS: if (last) begin
        s = enter(PH_ACC, cur); nxt_phase = s.ph; nxt_cnt = s.cnt;
      end
      PH_ACC: if (last) begin
        if (cur.page) begin
          nxt_phase = PH_PAGE; nxt_cnt = beat_len; nxt_beat = BEAT_W'(1);
        end else begin
          s = enter(PH_COH, cur); nxt_phase = s.ph; nxt_cnt = s.cnt;
        end
      end
      PH_PAGE: if (last) begin
        if (beat == BEAT_W'(PAGE_BEATS - 1)) begin
          s = enter(PH_COH, cur); nxt_phase = s.ph; nxt_cnt = s.cnt;
        end else begin
          nxt_phase = PH_PAGE; nxt_cnt = beat_len; nxt_beat = beat + BEAT_W'(1);
        end
      end
      PH_COH: if (last) begin
        s = enter(PH_CAH, cur); nxt_phase = s.ph; nxt_cnt = s.cnt;
      end
      PH_CAH: if (last) begin
        nxt_phase = PH_IDLE; nxt_cnt = '0;
      end
      default: begin
        nxt_phase = PH_IDLE; nxt_cnt = '0;
      end
    endcase
  end

  always_comb begin
    sel = '0;
    sel[nxt_bank] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase        <= PH_IDLE;
      cnt          <= '0;
      beat         <= '0;
      cur          <= '0;
      bank_q       <= '0;
      base_q       <= '0;
      mem_addr     <= '0;
      mem_addr_vld <= 1'b0;
      mem_cs_n     <= '1;
      mem_oe_n     <= 1'b1;
      rd_valid     <= 1'b0;
      rd_data      <= '0;
    end else begin
      phase        <= nxt_phase;
      cnt          <= nxt_cnt;
      beat         <= nxt_beat;
      cur          <= nxt_cfg;
      bank_q       <= nxt_bank;
      base_q       <= nxt_base;
      mem_addr_vld <= (nxt_phase != PH_IDLE);
      mem_oe_n     <= !(nxt_phase inside {PH_ACC, PH_PAGE});
      mem_cs_n     <= (nxt_phase inside {PH_COS, PH_ACC, PH_PAGE, PH_COH}) ? ~sel : '1;
      if (nxt_phase != PH_IDLE) mem_addr <= beat_addr(nxt_base, nxt_beat, nxt_cfg);
      rd_valid     <= sample;
      if (sample)
        rd_data <= cur.wide ? mem_data : {{HALF_W{1'b0}}, mem_data[HALF_W-1:0]};
    end
  end
endmodule

// File: rtl/smc_read_seq.sv
module smc_read_seq
  import smc_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int PAGE_BEATS = 4,
  localparam int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [BANK_W-1:0]    cfg_bank,
  input  logic [TW-1:0]        cfg_acs,
  input  logic [TW-1:0]        cfg_cos,
  input  logic [TACC_W-1:0]    cfg_acc,
  input  logic [TW-1:0]        cfg_coh,
  input  logic [TW-1:0]        cfg_cah,
  input  logic [TW-1:0]        cfg_acp,
  input  logic                 cfg_wide,
  input  logic                 cfg_page,
  input  logic                 req_valid,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 req_ready,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_addr_vld,
  output logic [NUM_BANKS-1:0] mem_cs_n,
  output logic                 mem_oe_n,
  input  logic [DATA_W-1:0]    mem_data
);
  bank_cfg_t wr_cfg, sel_cfg;

  always_comb begin
    wr_cfg      = '0;
    wr_cfg.page = cfg_page;
    wr_cfg.wide = cfg_wide;
    wr_cfg.acp  = cfg_acp;
    wr_cfg.cah  = cfg_cah;
    wr_cfg.coh  = cfg_coh;
    wr_cfg.cos  = cfg_cos;
    wr_cfg.acs  = cfg_acs;
    wr_cfg.acc  = cfg_acc;
  end

  smc_cfg_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_bank(cfg_bank), .wr_cfg(wr_cfg),
    .rd_bank(req_bank), .rd_cfg(sel_cfg)
  );

  smc_seq #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BEATS(PAGE_BEATS)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
    .req_addr(req_addr), .cfg_in(sel_cfg), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_addr_vld(mem_addr_vld), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_data(mem_data)
  );
endmodule

// File: rtl/smc_read_seq_chk.sv
module smc_read_seq_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 rd_valid,
  input logic                 mem_addr_vld,
  input logic [NUM_BANKS-1:0] mem_cs_n,
  input logic                 mem_oe_n
);
  AST_CS_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n)); // R2
  AST_OE_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !(&mem_cs_n)); // R3
  AST_DATA_AFTER_OE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!mem_oe_n)); // R4
  AST_CS_INSIDE_ADDR: assert property (@(posedge clk) disable iff (rst)
    !(&mem_cs_n) |-> mem_addr_vld); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    mem_addr_vld |-> !req_ready); // R6
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R6
endmodule

bind smc_read_seq smc_read_seq_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .mem_addr_vld(mem_addr_vld), .mem_cs_n(mem_cs_n),
  .mem_oe_n(mem_oe_n)
);

// File: tb/smc_read_seq_tb.sv
module smc_read_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_bank = '0;
  logic [3:0]  cfg_acs = '0, cfg_cos = '0, cfg_coh = '0, cfg_cah = '0, cfg_acp = '0;
  logic [4:0]  cfg_acc = '0;
  logic        cfg_wide = 1'b0, cfg_page = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [23:0] req_addr = '0;
  logic        req_ready, rd_valid, mem_addr_vld, mem_oe_n;
  logic [15:0] rd_data, mem_data;
  logic [23:0] mem_addr;
  logic [3:0]  mem_cs_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_data = {~mem_addr[7:0], mem_addr[7:0]};

  smc_read_seq u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_acs(cfg_acs), .cfg_cos(cfg_cos), .cfg_acc(cfg_acc), .cfg_coh(cfg_coh),
    .cfg_cah(cfg_cah), .cfg_acp(cfg_acp), .cfg_wide(cfg_wide), .cfg_page(cfg_page),
    .req_valid(req_valid), .req_bank(req_bank), .req_addr(req_addr),
    .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_addr_vld(mem_addr_vld), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_data(mem_data)
  );

  typedef struct { int acs; int cos; int oe; int coh; int cah; int bank; } tim_t;
  tim_t        tq[$];
  logic [15:0] dq[$];
  int checks = 0, fails = 0;

  // bench model of the per-bank timing sets
  int m_acs[4], m_cos[4], m_acc[4], m_coh[4], m_cah[4], m_acp[4];
  bit m_wide[4], m_page[4];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(int b, int acs, int cos, int acc, int coh, int cah,
                           int acp, bit wide, bit page);
    while (tq.size() != 0 || !req_ready) @(negedge clk);
    cfg_bank = 2'(b); cfg_acs = 4'(acs); cfg_cos = 4'(cos); cfg_acc = 5'(acc);
    cfg_coh = 4'(coh); cfg_cah = 4'(cah); cfg_acp = 4'(acp);
    cfg_wide = wide; cfg_page = page; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    m_acs[b] = acs; m_cos[b] = cos; m_acc[b] = acc; m_coh[b] = coh;
    m_cah[b] = cah; m_acp[b] = acp; m_wide[b] = wide; m_page[b] = page;
  endtask

  // driver: push expectations, then hand the request to the design
  task automatic do_read(int b, logic [23:0] a);
    tim_t t;
    int   nb, lane, bl;
    logic [23:0] ea, mask;
    nb   = m_page[b] ? 4 : 1;
    lane = m_wide[b] ? 1 : 0;
    bl   = (m_acp[b] == 0) ? 1 : m_acp[b];
    mask = 24'(3) << lane;
    for (int k = 0; k < nb; k++) begin
      ea = m_page[b] ? ((a & ~mask) | (24'(k) << lane)) : a;
      dq.push_back(m_wide[b] ? {~ea[7:0], ea[7:0]} : {8'h00, ea[7:0]});
    end
    t.acs = m_acs[b]; t.cos = m_cos[b]; t.coh = m_coh[b]; t.cah = m_cah[b];
    t.oe  = m_acc[b] + 1 + (m_page[b] ? 3 * bl : 0);
    t.bank = b;
    tq.push_back(t);
    @(negedge clk);
    req_valid = 1'b1; req_bank = 2'(b); req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: data beats
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (dq.size() == 0) chk(1'b0, "R4", "unexpected beat", 1, 0);
      else begin
        logic [15:0] e;
        e = dq.pop_front();
        chk(rd_data == e, "R8/R7/R4", "read word", int'(rd_data), int'(e));
      end
    end
  end

  // monitor: phase lengths measured at the pins
  int  n_acs = 0, n_cos = 0, n_oe = 0, n_coh = 0, n_cah = 0;
  bit  seen_cs = 0, seen_oe = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!(&mem_cs_n) && tq.size() != 0)
        if (mem_cs_n != ~(4'b1 << tq[0].bank))
          chk(1'b0, "R2", "chip-select bank", int'(mem_cs_n), int'(~(4'b1 << tq[0].bank)));
      if (mem_addr_vld && (&mem_cs_n) && !seen_cs) n_acs++;
      if (!(&mem_cs_n) && mem_oe_n && !seen_oe) begin n_cos++; seen_cs = 1; end
      if (!mem_oe_n) begin n_oe++; seen_cs = 1; seen_oe = 1; end
      if (!(&mem_cs_n) && mem_oe_n && seen_oe) n_coh++;
      if (mem_addr_vld && (&mem_cs_n) && seen_cs) n_cah++;
      if (!mem_addr_vld && seen_cs) begin
        if (tq.size() == 0) chk(1'b0, "R2", "unexpected access", 1, 0);
        else begin
          tim_t t;
          t = tq.pop_front();
          chk(n_acs == t.acs, "R2", "address setup", n_acs, t.acs);
          chk(n_cos == t.cos, "R3", "chip-select setup", n_cos, t.cos);
          chk(n_oe  == t.oe,  "R4/R7", "output-enable low", n_oe, t.oe);
          chk(n_coh == t.coh, "R5", "chip-select hold", n_coh, t.coh);
          chk(n_cah == t.cah, "R6", "address hold", n_cah, t.cah);
          chk(req_ready == 1'b1, "R6", "ready after hold", int'(req_ready), 1);
        end
        n_acs = 0; n_cos = 0; n_oe = 0; n_coh = 0; n_cah = 0;
        seen_cs = 0; seen_oe = 0;
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    finish_run();
  end

  initial begin
    for (int b = 0; b < 4; b++) begin
      m_acs[b] = 0; m_cos[b] = 0; m_acc[b] = 0; m_coh[b] = 0;
      m_cah[b] = 0; m_acp[b] = 0; m_wide[b] = 0; m_page[b] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: idle state under reset and just after it
    chk(mem_cs_n == 4'hF, "R1", "cs_n in reset", int'(mem_cs_n), 15);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_cs_n == 4'hF, "R1", "cs_n idle", int'(mem_cs_n), 15);
    chk(mem_oe_n == 1'b1, "R1", "oe_n idle", int'(mem_oe_n), 1);
    chk(mem_addr_vld == 1'b0, "R1", "address valid idle", int'(mem_addr_vld), 0);
    chk(rd_valid == 1'b0, "R1", "rd_valid idle", int'(rd_valid), 0);
    chk(req_ready == 1'b1, "R1", "ready idle", int'(req_ready), 1);

    // R9: bank never written, all defaults
    do_read(0, 24'h0000C3);
    // mixed timing, two-byte single beat (R2..R6, R8)
    cfg_write(1, 3, 2, 4, 1, 2, 0, 1'b1, 1'b0);
    do_read(1, 24'h001234);
    // page mode, one-byte bank, nonzero beat time (R7)
    cfg_write(2, 1, 1, 5, 1, 1, 2, 1'b0, 1'b1);
    do_read(2, 24'h000127);
    // page mode, two-byte bank, zero beat time clamps to one cycle (R7)
    cfg_write(3, 0, 0, 31, 0, 0, 0, 1'b1, 1'b1);
    do_read(3, 24'h0055AB);
    // every field at its maximum (R2..R6)
    cfg_write(1, 15, 15, 31, 15, 15, 15, 1'b0, 1'b0);
    do_read(1, 24'hABCDEF);
    // R10: bank 0 still has its reset timing after other banks were written
    do_read(0, 24'h00007E);
    // back-to-back requests over different banks (R6)
    do_read(2, 24'h000200);
    do_read(3, 24'h000010);
    do_read(0, 24'h000011);
    while (tq.size() != 0 || dq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(dq.size() == 0, "R7", "beats outstanding", dq.size(), 0);
    chk(mem_cs_n == 4'hF, "R1", "cs_n idle at end", int'(mem_cs_n), 15);
    finish_run();
  end
endmodule